// File: doc/BRIEF.md
# Line Latch with Alternating Channel Polarity

This block sits between the serial capture register of a column driver and its per-channel digital-to-analog converters. It holds one horizontal line of 6-bit grey codes and releases them to the converters once per line. A line strobe, synchronised to the system clock, controls the release. When the strobe goes high the captured codes are copied into the output latch and every channel stops driving. When the strobe goes low again every channel drives its latched code.

Each channel also carries a half-select bit. This bit picks the reference group above the common level or the one below it. Neighbouring channels always take opposite groups. A polarity input, sampled at the strobe's rising edge, decides which parity of channel gets the upper group. The converter ladder itself is outside the block. It is represented only by the code, the half-select and the drive enable of each channel.

Top module: `lineLatchDriver`

## Requirements
- R1: While reset is asserted, and after reset until the first complete strobe pulse, every drive enable is 0, every level code is 0 and every half-select is 0. The latch holds zero and the applied polarity is low.
- R2: A strobe rising edge that is sampled high on at least two consecutive clock edges qualifies. All drive enables go low on the fourth rising clock edge after the first high sample. While the enables are low, every level code and half-select output reads 0.
- R3: After a qualified pulse, all drive enables return to 1 on the third rising clock edge after the strobe is first sampled low. Channel k then presents on levelCode[k*6 +: 6] exactly the code that was on codesIn[k*6 +: 6] at the qualified rise, without alteration.
- R4: Changes on codesIn after the qualified rise, including while the strobe is still high, do not alter the line being driven.
- R5: halfSel=1 selects the upper reference group, where code 00h is the highest level and 3Fh the lowest. halfSel=0 selects the lower group, where 00h is the lowest level and 3Fh the highest. With the applied polarity low, even-indexed channels (0, 2, 4, ...) take the upper group and odd-indexed channels take the lower group. Polarity high swaps the two.
- R6: The applied polarity is the value of polarityIn at the clock edge where the strobe is first sampled high. Changes to polarityIn while the strobe stays high have no effect on that line.
- R7: A strobe pulse that is sampled high on only one clock edge is ignored. The drive enables, codes and half-selects that are currently driven stay unchanged, and the latch is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobeIn | input | 1 | Line strobe, asynchronous to clk |
| polarityIn | input | 1 | Polarity select, sampled at the strobe rising edge |
| codesIn | input | NUM_CH*CODE_W | Captured codes; channel k in bits [k*CODE_W +: CODE_W] |
| driveEn | output | NUM_CH | Per-channel drive enable (0 = high impedance) |
| halfSel | output | NUM_CH | Per-channel reference group (1 = upper) |
| levelCode | output | NUM_CH*CODE_W | Per-channel code for the converter |

## Verification
The bench builds the block with seven channels and the default two-stage synchroniser. With these values every channel of every line can be compared in one word. The odd channel count leaves the last channel as an even-indexed, upper-group channel, so the half-select alternation is checked at the end of the row as well as the start. Code patterns include all-zero, all-ones and wrapping ramps. The enable timing is checked on the exact clock edge in both directions, and strobes of one clock and of several clocks are both applied.

// File: rtl/lineLatchPkg.sv
package lineLatchPkg;
  // strobes from control to the datapath
  typedef struct packed {
    logic loadLine;   // one-cycle pulse: copy captured codes into the latch
    logic driveOn;    // outputs driven (low = high impedance)
    logic polarity;   // applied polarity for the current line
  } latchCtrl_t;
endpackage

// File: rtl/lineStrobeCtrl.sv
module lineStrobeCtrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeIn,
  input  logic polarityIn,
  output lineLatchPkg::latchCtrl_t ctrl
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] strobePipe;
  logic [PIPE_W-1:0] polPipe;
  logic sNow, sPrev, polAtEdge;
  logic armed, driveOn, polApplied;
  logic riseQual, fallQual;

  // synchroniser plus one extra stage for edge qualification
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePipe <= '0;
      polPipe    <= '0;
    end else begin
      strobePipe <= {strobePipe[PIPE_W-2:0], strobeIn};
      polPipe    <= {polPipe[PIPE_W-2:0], polarityIn};
    end
  end

  assign sNow      = strobePipe[SYNC_STAGES-1];
  assign sPrev     = strobePipe[SYNC_STAGES];
  // polarity aligned with the first high strobe sample
  assign polAtEdge = polPipe[SYNC_STAGES];

  // two consecutive high samples qualify a rise
  assign riseQual = sNow & sPrev & ~armed;
  assign fallQual = armed & ~sNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      driveOn    <= 1'b0;
      polApplied <= 1'b0;
    end else begin
      if (riseQual) begin
        armed      <= 1'b1;
        driveOn    <= 1'b0;
        polApplied <= polAtEdge;
      end else if (fallQual) begin
        armed   <= 1'b0;
        driveOn <= 1'b1;
      end
    end
  end

  assign ctrl.loadLine = riseQual;
  assign ctrl.driveOn  = driveOn;
  assign ctrl.polarity = polApplied;

  assert_rise_blanks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sNow && sPrev && !armed) |=> !driveOn);

  assert_release_after_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveOn) |-> $past(!sNow));

  assert_short_pulse_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && sNow && !sPrev) ##1 (!sNow) |=> !armed);

  assert_pol_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(sNow && sPrev && !armed) |=> $stable(polApplied));
endmodule

// File: rtl/lineLatchPath.sv
module lineLatchPath #(
  parameter int NUM_CH = 300,
  parameter int CODE_W = 6
) (
  input  logic clk,
  input  logic rstN,
  input  lineLatchPkg::latchCtrl_t ctrl,
  input  logic [NUM_CH*CODE_W-1:0] codesIn,
  output logic [NUM_CH-1:0] driveEn,
  output logic [NUM_CH-1:0] halfSel,
  output logic [NUM_CH*CODE_W-1:0] levelCode
);
  logic [NUM_CH-1:0][CODE_W-1:0] latchReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchReg <= '0;
    end else if (ctrl.loadLine) begin
      latchReg <= codesIn;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    // even index takes the upper group when polarity is low
    localparam bit EVEN_IDX = (ch % 2) == 0;
    logic upperGroup;
    if (EVEN_IDX) begin : gEven
      assign upperGroup = ~ctrl.polarity;
    end else begin : gOdd
      assign upperGroup = ctrl.polarity;
    end
    assign driveEn[ch] = ctrl.driveOn;
    assign halfSel[ch] = ctrl.driveOn & upperGroup;
    assign levelCode[ch*CODE_W +: CODE_W] = ctrl.driveOn ? latchReg[ch] : '0;
  end

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadLine |=> $stable(latchReg));

  if (NUM_CH >= 2) begin : gPairChk
    assert_opposite_halves_R5: assert property (@(posedge clk) disable iff (!rstN)
      driveEn[0] |-> (halfSel[0] != halfSel[1]));
  end
endmodule

// File: rtl/lineLatchDriver.sv
module lineLatchDriver #(
  parameter int NUM_CH      = 300,
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeIn,
  input  logic polarityIn,
  input  logic [NUM_CH*CODE_W-1:0] codesIn,
  output logic [NUM_CH-1:0] driveEn,
  output logic [NUM_CH-1:0] halfSel,
  output logic [NUM_CH*CODE_W-1:0] levelCode
);
  lineLatchPkg::latchCtrl_t ctrl;

  lineStrobeCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .polarityIn(polarityIn), .ctrl(ctrl)
  );

  lineLatchPath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .codesIn(codesIn),
    .driveEn(driveEn), .halfSel(halfSel), .levelCode(levelCode)
  );
endmodule

// File: tb/test_lineLatchDriver.sv
module test_lineLatchDriver;
  localparam int NUM_CH = 7;
  localparam int CODE_W = 6;
  localparam int BUS_W  = NUM_CH * CODE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobeIn = 1'b0;
  logic polarityIn = 1'b0;
  logic [BUS_W-1:0] codesIn = '0;
  logic [NUM_CH-1:0] driveEn, halfSel;
  logic [BUS_W-1:0] levelCode;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  lineLatchDriver #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .SYNC_STAGES(2)) i_lineLatchDriver (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .polarityIn(polarityIn),
    .codesIn(codesIn), .driveEn(driveEn), .halfSel(halfSel), .levelCode(levelCode)
  );

  // {polarity, seed, step}
  localparam logic [12:0] VEC [0:5] = '{
    {1'b0, 6'h00, 6'h00},
    {1'b1, 6'h3F, 6'h00},
    {1'b0, 6'h01, 6'h09},
    {1'b1, 6'h2A, 6'h15},
    {1'b0, 6'h3F, 6'h01},
    {1'b1, 6'h10, 6'h3F}
  };

  function automatic logic [BUS_W-1:0] mkCodes(input logic [5:0] seed, input logic [5:0] step);
    logic [BUS_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      logic [CODE_W-1:0] c;
      c = CODE_W'(seed + step * i);
      r[i*CODE_W +: CODE_W] = c;
    end
    return r;
  endfunction

  function automatic logic [NUM_CH-1:0] expHalf(input logic pol);
    logic [NUM_CH-1:0] h;
    for (int i = 0; i < NUM_CH; i++) h[i] = ((i % 2) == 0) ? ~pol : pol;
    return h;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkOff(input string req);
    chk({req, " enables"}, 64'(driveEn), 64'd0);
    chk({req, " codes"}, 64'(levelCode), 64'd0);
    chk({req, " halves"}, 64'(halfSel), 64'd0);
  endtask

  task automatic chkOn(input string req, input logic [BUS_W-1:0] codes, input logic pol);
    chk({req, " enables"}, 64'(driveEn), 64'({NUM_CH{1'b1}}));
    chk({req, " codes"}, 64'(levelCode), 64'(codes));
    chk({req, " halves"}, 64'(halfSel), 64'(expHalf(pol)));
  endtask

  // full line; mid values are applied while the strobe is still high
  task automatic runLine(input logic [BUS_W-1:0] codes, input logic pol,
                         input logic [BUS_W-1:0] midCodes, input logic midPol, input string req);
    @(negedge clk);
    codesIn = codes; polarityIn = pol; strobeIn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chkOff({req, " R2 blank while high"});
    codesIn = midCodes; polarityIn = midPol;
    @(posedge clk);
    @(negedge clk);
    strobeIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chkOff({req, " R3 still blank two edges after low"});
    @(posedge clk);
    @(negedge clk);
    chkOn({req, " R3 R5 driven after fall"}, codes, pol);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [BUS_W-1:0] cA, cB;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkOff("R1 during reset");
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chkOff("R1 after reset before strobe");

    // table walk (R2, R3, R5)
    for (int v = 0; v < 6; v++) begin
      logic [BUS_W-1:0] cv;
      cv = mkCodes(VEC[v][11:6], VEC[v][5:0]);
      runLine(cv, VEC[v][12], cv, VEC[v][12], $sformatf("vec%0d", v));
    end

    // R2: exact disable edge from an enabled state
    cA = mkCodes(6'h05, 6'h07);
    @(negedge clk);
    codesIn = cA; polarityIn = 1'b0; strobeIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 enables still on after three edges", 64'(driveEn), 64'({NUM_CH{1'b1}}));
    @(posedge clk);
    @(negedge clk);
    chkOff("R2 off on fourth edge");
    strobeIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkOn("R3 line after R2 test", cA, 1'b0);

    // R4 and R6: codes and polarity changed while strobe high
    cB = mkCodes(6'h30, 6'h0B);
    runLine(cA, 1'b1, cB, 1'b0, "R4 R6 mid-line change");

    // R7: one-sample strobe with new codes and polarity is ignored
    @(negedge clk);
    codesIn = cB; polarityIn = 1'b0; strobeIn = 1'b1;
    @(negedge clk);
    strobeIn = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chkOn("R7 short pulse ignored", cA, 1'b1);

    // R7: latch not reloaded by the short pulse; next full line uses fresh codes
    runLine(cB, 1'b0, cB, 1'b0, "R7 follow-up line");

    // R1: reset in the middle of operation clears everything
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chkOff("R1 reset mid-operation");
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chkOff("R1 stays off after second reset");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule